// File: doc/BRIEF.md
# Operand Address Generator

This block works out the location or the literal value of one operand of a CPU with 16-bit opcodes. The decode stage gives it an addressing mode code, a register number, an operand size, the program counter as it stands just after the opcode word, a quick literal, and the present contents of the eight data and eight address registers. When a mode needs extension words, the block requests them one at a time from the instruction stream. It then returns the effective address or the value, a flag telling the operand stage whether memory has to be read, and the number of instruction-stream bytes it consumed.

Modes that move an address register (post-increment and pre-decrement) also produce a register write-back: a register number, a new value and a strobe that is high for exactly the cycle in which the result is presented. The byte-size step comes from a per-register table, so that the stack-pointer register can keep word alignment. A mode or size code that the block does not support produces an illegal-mode result with no side effects.

The decode stage pulses `start` with the operand description. It holds the register-file inputs steady until `done` and then reads every result in the cycle when `done` is high.

Top module: `eagu`

## Requirements
- R1: Mode 0 returns data register `reg_sel`, mode 1 returns address register `reg_sel` and mode 12 returns `quick_in`. None of them consumes an extension word and all three clear `needs_fetch`. `done` rises in the cycle after the `start` cycle.
- R2: `pc_step` equals twice the number of extension words consumed. `done` is high for one cycle only, and it comes one cycle after the last extension word is accepted.
- R3: Mode 3 (post-increment) returns the old address register value with `needs_fetch` set. In the same cycle as `done` it raises `wb_en` with `wb_reg`=`reg_sel` and `wb_val` = old value + step. The step is 2 for size code 1 (word) and 4 for size code 2 (long).
- R4: Mode 4 (pre-decrement) returns old value − step and writes back that same value, with `needs_fetch` set.
- R5: For size code 0 (byte), the step in modes 3 and 4 is 1 for every register except register 7, which steps by 2.
- R6: Mode 2 returns the address register with `needs_fetch` set. Mode 5 returns the address register plus the sign-extended 16-bit extension word, and mode 9 returns `pc_in` plus that word. Both take one word.
- R7: Modes 6 (address register base) and 10 (`pc_in` base) take one index word. Bit 15 of that word picks an address (1) or data (0) index register, and bits 14..12 give its number. Bit 11 set uses all 32 bits of the index; clear uses its low 16 bits sign-extended. Bits 7..0 are a signed displacement that is also added.
- R8: Mode 7 returns one extension word sign-extended. Mode 8 returns two words, the first being the upper half. Both set `needs_fetch`.
- R9: Mode 11 (immediate) clears `needs_fetch`. Byte size takes one word and keeps its low 8 bits zero-extended, word size takes one word zero-extended, and long size takes two words with the first as the upper half.
- R10: Mode codes 13–15, or size code 3, give `done` with `illegal` set, `ea_out`=0, `pc_step`=0, `needs_fetch` clear and no write-back.
- R11: A `start` pulse that arrives while extension words are still being collected is ignored: the operation in progress completes unchanged and no extra `done` follows.
- R12: `ext_req` stays high until `ext_valid` is seen with it. Each such cycle accepts one word, and `done` is never high while `ext_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand calculation |
| mode | input | 4 | Addressing mode code |
| reg_sel | input | 3 | Register number for the mode |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| pc_in | input | 32 | Program counter after the opcode |
| quick_in | input | 32 | Literal for quick mode |
| dregs | input | 256 | Data registers, register n at bits 32n+31..32n |
| aregs | input | 256 | Address registers, same packing |
| ext_req | output | 1 | Requesting an extension word |
| ext_valid | input | 1 | Extension word present |
| ext_word | input | 16 | Extension word |
| done | output | 1 | Result valid this cycle |
| ea_out | output | 32 | Effective address or value |
| needs_fetch | output | 1 | Operand must be read from memory |
| illegal | output | 1 | Unsupported mode or size |
| pc_step | output | 3 | Bytes of instruction stream consumed |
| wb_en | output | 1 | Register write-back strobe |
| wb_reg | output | 3 | Address register to write |
| wb_val | output | 32 | Value to write |

## Verification
The hardest case to reach is a `start` pulse landing during a multi-word collection, since the window only exists while the instruction stream is stalling. The bench builds that window on purpose. It holds `ext_valid` low for several cycles during a two-word absolute-long fetch and pulses `start` with a conflicting mode inside the stall. It then checks that the original result, the cycle count and a single `done` are all unchanged. The stack-pointer byte step is reached by running byte post-increment and pre-decrement on register 7 next to the same operations on an ordinary register.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    localparam logic [3:0] MD_DREG    = 4'd0;
    localparam logic [3:0] MD_AREG    = 4'd1;
    localparam logic [3:0] MD_IND     = 4'd2;
    localparam logic [3:0] MD_POSTINC = 4'd3;
    localparam logic [3:0] MD_PREDEC  = 4'd4;
    localparam logic [3:0] MD_DISP    = 4'd5;
    localparam logic [3:0] MD_INDEX   = 4'd6;
    localparam logic [3:0] MD_ABSW    = 4'd7;
    localparam logic [3:0] MD_ABSL    = 4'd8;
    localparam logic [3:0] MD_PCDISP  = 4'd9;
    localparam logic [3:0] MD_PCINDEX = 4'd10;
    localparam logic [3:0] MD_IMM     = 4'd11;
    localparam logic [3:0] MD_QUICK   = 4'd12;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    typedef enum logic {ST_IDLE, ST_FETCH} st_e;

    function automatic logic mode_bad(input logic [3:0] m, input logic [1:0] sz);
        return (m > MD_QUICK) || (sz == SZ_BAD);
    endfunction

    // Extension words a mode pulls from the instruction stream.
    function automatic logic [1:0] ext_words(input logic [3:0] m, input logic [1:0] sz);
        logic [1:0] n;
        n = 2'd0;
        if (!mode_bad(m, sz)) begin
            case (m)
                MD_DISP, MD_INDEX, MD_ABSW, MD_PCDISP, MD_PCINDEX: n = 2'd1;
                MD_ABSL: n = 2'd2;
                MD_IMM:  n = (sz == SZ_LONG) ? 2'd2 : 2'd1;
                default: n = 2'd0;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/eagu_step.sv
module eagu_step #(
    parameter int AW           = 32,
    parameter int NREG         = 8,
    parameter int SP_REG       = 7,
    parameter int SP_BYTE_STEP = 2,
    localparam int RW          = $clog2(NREG)
) (
    input  logic [RW-1:0] rsel,
    input  logic [1:0]    size,
    output logic [AW-1:0] step
);
    import eagu_pkg::*;

    logic [3:0] byte_step [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_tab
            if (g == SP_REG) begin : g_sp
                assign byte_step[g] = 4'(SP_BYTE_STEP);
            end else begin : g_gp
                assign byte_step[g] = 4'd1;
            end
        end
    endgenerate

    always_comb begin
        case (size)
            SZ_BYTE: step = AW'(byte_step[rsel]);
            SZ_WORD: step = AW'(2);
            default: step = AW'(4);
        endcase
    end
endmodule

// File: rtl/eagu_index.sv
module eagu_index #(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  logic             use_areg,
    input  logic [2:0]       inum,
    input  logic             full_width,
    input  logic [7:0]       disp8,
    input  logic [NREG*AW-1:0] dregs,
    input  logic [NREG*AW-1:0] aregs,
    output logic [AW-1:0]    offset
);
    logic [AW-1:0] raw;
    logic [AW-1:0] sized;

    always_comb begin
        raw    = use_areg ? aregs[int'(inum)*AW +: AW] : dregs[int'(inum)*AW +: AW];
        sized  = full_width ? raw : {{(AW-16){raw[15]}}, raw[15:0]};
        offset = sized + {{(AW-8){disp8[7]}}, disp8};
    end
endmodule

// File: rtl/eagu_calc.sv
module eagu_calc #(
    parameter int AW           = 32,
    parameter int NREG         = 8,
    parameter int SP_REG       = 7,
    parameter int SP_BYTE_STEP = 2,
    localparam int RW          = $clog2(NREG)
) (
    input  logic [3:0]         mode,
    input  logic [RW-1:0]      rsel,
    input  logic [1:0]         size,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      quick,
    input  logic [15:0]        w0,
    input  logic [15:0]        w1,
    input  logic [NREG*AW-1:0] dregs,
    input  logic [NREG*AW-1:0] aregs,
    output logic [AW-1:0]      value,
    output logic               fetch,
    output logic               bad,
    output logic               wb,
    output logic [AW-1:0]      wb_value
);
    import eagu_pkg::*;

    logic [AW-1:0] step;
    logic [AW-1:0] idx_off;
    logic [AW-1:0] base;
    logic [AW-1:0] dval;
    logic [AW-1:0] sx_w0;

    eagu_step #(.AW(AW), .NREG(NREG), .SP_REG(SP_REG), .SP_BYTE_STEP(SP_BYTE_STEP)) u_step (
        .rsel (rsel),
        .size (size),
        .step (step)
    );

    eagu_index #(.AW(AW), .NREG(NREG)) u_index (
        .use_areg   (w0[15]),
        .inum       (w0[14:12]),
        .full_width (w0[11]),
        .disp8      (w0[7:0]),
        .dregs      (dregs),
        .aregs      (aregs),
        .offset     (idx_off)
    );

    always_comb begin
        base     = aregs[int'(rsel)*AW +: AW];
        dval     = dregs[int'(rsel)*AW +: AW];
        sx_w0    = {{(AW-16){w0[15]}}, w0};
        value    = '0;
        fetch    = 1'b1;
        wb       = 1'b0;
        wb_value = '0;
        bad      = mode_bad(mode, size);
        case (mode)
            MD_DREG:    begin value = dval;  fetch = 1'b0; end
            MD_AREG:    begin value = base;  fetch = 1'b0; end
            MD_QUICK:   begin value = quick; fetch = 1'b0; end
            MD_IND:     value = base;
            MD_POSTINC: begin
                value    = base;
                wb       = 1'b1;
                wb_value = base + step;
            end
            MD_PREDEC:  begin
                value    = base - step;
                wb       = 1'b1;
                wb_value = base - step;
            end
            MD_DISP:    value = base + sx_w0;
            MD_INDEX:   value = base + idx_off;
            MD_ABSW:    value = sx_w0;
            MD_ABSL:    value = AW'({w0, w1});
            MD_PCDISP:  value = pc + sx_w0;
            MD_PCINDEX: value = pc + idx_off;
            MD_IMM:     begin
                fetch = 1'b0;
                case (size)
                    SZ_BYTE: value = AW'(w0[7:0]);
                    SZ_WORD: value = AW'(w0);
                    default: value = AW'({w0, w1});
                endcase
            end
            default:    value = '0;
        endcase
        if (bad) begin
            value    = '0;
            fetch    = 1'b0;
            wb       = 1'b0;
            wb_value = '0;
        end
    end
endmodule

// File: rtl/eagu.sv
module eagu #(
    parameter int AW           = 32,
    parameter int NREG         = 8,
    parameter int SP_REG       = 7,
    parameter int SP_BYTE_STEP = 2,
    localparam int RW          = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           mode,
    input  logic [RW-1:0]        reg_sel,
    input  logic [1:0]           size,
    input  logic [AW-1:0]        pc_in,
    input  logic [AW-1:0]        quick_in,
    input  logic [NREG*AW-1:0]   dregs,
    input  logic [NREG*AW-1:0]   aregs,
    output logic                 ext_req,
    input  logic                 ext_valid,
    input  logic [15:0]          ext_word,
    output logic                 done,
    output logic [AW-1:0]        ea_out,
    output logic                 needs_fetch,
    output logic                 illegal,
    output logic [2:0]           pc_step,
    output logic                 wb_en,
    output logic [RW-1:0]        wb_reg,
    output logic [AW-1:0]        wb_val
);
    import eagu_pkg::*;

    typedef struct packed {
        st_e           st;
        logic [3:0]    mode;
        logic [RW-1:0] rsel;
        logic [1:0]    size;
        logic [AW-1:0] pc;
        logic [15:0]   w0;
        logic [1:0]    need;
        logic [1:0]    cnt;
        logic          done;
        logic [AW-1:0] val;
        logic          fetch;
        logic          bad;
        logic [2:0]    step;
        logic          wb;
        logic [RW-1:0] wbr;
        logic [AW-1:0] wbv;
    } regs_t;

    regs_t q, d;

    logic [3:0]    c_mode;
    logic [RW-1:0] c_rsel;
    logic [1:0]    c_size;
    logic [AW-1:0] c_pc;
    logic [15:0]   c_w0;
    logic [AW-1:0] c_val;
    logic          c_fetch;
    logic          c_bad;
    logic          c_wb;
    logic [AW-1:0] c_wbv;
    logic [1:0]    start_need;

    always_comb begin
        if (q.st == ST_IDLE) begin
            c_mode = mode;
            c_rsel = reg_sel;
            c_size = size;
            c_pc   = pc_in;
        end else begin
            c_mode = q.mode;
            c_rsel = q.rsel;
            c_size = q.size;
            c_pc   = q.pc;
        end
        c_w0 = (q.st == ST_FETCH && q.cnt != 2'd0) ? q.w0 : ext_word;
    end

    eagu_calc #(.AW(AW), .NREG(NREG), .SP_REG(SP_REG), .SP_BYTE_STEP(SP_BYTE_STEP)) u_calc (
        .mode     (c_mode),
        .rsel     (c_rsel),
        .size     (c_size),
        .pc       (c_pc),
        .quick    (quick_in),
        .w0       (c_w0),
        .w1       (ext_word),
        .dregs    (dregs),
        .aregs    (aregs),
        .value    (c_val),
        .fetch    (c_fetch),
        .bad      (c_bad),
        .wb       (c_wb),
        .wb_value (c_wbv)
    );

    assign start_need = ext_words(mode, size);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.wb   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mode = mode;
                    d.rsel = reg_sel;
                    d.size = size;
                    d.pc   = pc_in;
                    d.need = start_need;
                    d.cnt  = 2'd0;
                    if (start_need == 2'd0) begin
                        d.done  = 1'b1;
                        d.val   = c_val;
                        d.fetch = c_fetch;
                        d.bad   = c_bad;
                        d.step  = 3'd0;
                        d.wb    = c_wb;
                        d.wbr   = reg_sel;
                        d.wbv   = c_wbv;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            default: begin
                if (ext_valid) begin
                    if (q.cnt == 2'd0) d.w0 = ext_word;
                    d.cnt = q.cnt + 2'd1;
                    if (q.cnt + 2'd1 == q.need) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.val   = c_val;
                        d.fetch = c_fetch;
                        d.bad   = c_bad;
                        d.step  = {q.need, 1'b0};
                        d.wb    = c_wb;
                        d.wbr   = q.rsel;
                        d.wbv   = c_wbv;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ext_req     = (q.st == ST_FETCH);
    assign done        = q.done;
    assign ea_out      = q.val;
    assign needs_fetch = q.fetch;
    assign illegal     = q.bad;
    assign pc_step     = q.step;
    assign wb_en       = q.wb;
    assign wb_reg      = q.wbr;
    assign wb_val      = q.wbv;
endmodule

// File: rtl/eagu_chk.sv
module eagu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_req,
    input logic       ext_valid,
    input logic       done,
    input logic       needs_fetch,
    input logic       illegal,
    input logic [2:0] pc_step,
    input logic       wb_en
);
    assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    assert_wb_is_memory_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> needs_fetch);

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!wb_en && !needs_fetch && pc_step == 3'd0));

    assert_req_excl_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> !done);

    assert_req_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_valid) |=> ext_req);

    assert_step_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!pc_step[0] && pc_step <= 3'd4));
endmodule

bind eagu eagu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_req     (ext_req),
    .ext_valid   (ext_valid),
    .done        (done),
    .needs_fetch (needs_fetch),
    .illegal     (illegal),
    .pc_step     (pc_step),
    .wb_en       (wb_en)
);

// File: tb/eagu_test.sv
module eagu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  size = '0;
    logic [31:0] pc_in = 32'h0000_4002;
    logic [31:0] quick_in = 32'h0000_0005;
    logic [255:0] dregs, aregs;
    logic        ext_req, ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        done, needs_fetch, illegal, wb_en;
    logic [31:0] ea_out, wb_val;
    logic [2:0]  pc_step, wb_reg;

    logic [31:0] dr [8];
    logic [31:0] ar [8];
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            dregs[i*32 +: 32] = dr[i];
            aregs[i*32 +: 32] = ar[i];
        end
    end

    eagu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
        .size(size), .pc_in(pc_in), .quick_in(quick_in), .dregs(dregs), .aregs(aregs),
        .ext_req(ext_req), .ext_valid(ext_valid), .ext_word(ext_word), .done(done),
        .ea_out(ea_out), .needs_fetch(needs_fetch), .illegal(illegal), .pc_step(pc_step),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] w);
        return {{16{w[15]}}, w};
    endfunction

    // Reference model, written from the requirement text.
    task automatic model(input logic [3:0] m, input logic [2:0] r, input logic [1:0] sz,
                         input logic [15:0] w0, input logic [15:0] w1,
                         output logic [31:0] v, output logic f, output logic bad,
                         output logic wb, output logic [31:0] wv, output int words);
        logic [31:0] step, iv, idx;
        bad = (m > 4'd12) || (sz == 2'd3);
        step = (sz == 2'd0) ? ((r == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1) ? 32'd2 : 32'd4;
        iv = w0[15] ? ar[w0[14:12]] : dr[w0[14:12]];
        if (!w0[11]) iv = sx16(iv[15:0]);
        idx = iv + {{24{w0[7]}}, w0[7:0]};
        v = 0; f = 1; wb = 0; wv = 0; words = 0;
        case (m)
            0: begin v = dr[r]; f = 0; end
            1: begin v = ar[r]; f = 0; end
            12: begin v = quick_in; f = 0; end
            2: v = ar[r];
            3: begin v = ar[r]; wb = 1; wv = ar[r] + step; end
            4: begin v = ar[r] - step; wb = 1; wv = v; end
            5: begin v = ar[r] + sx16(w0); words = 1; end
            6: begin v = ar[r] + idx; words = 1; end
            7: begin v = sx16(w0); words = 1; end
            8: begin v = {w0, w1}; words = 2; end
            9: begin v = pc_in + sx16(w0); words = 1; end
            10: begin v = pc_in + idx; words = 1; end
            11: begin
                f = 0;
                if (sz == 2'd0) begin v = {24'd0, w0[7:0]}; words = 1; end
                else if (sz == 2'd1) begin v = {16'd0, w0}; words = 1; end
                else begin v = {w0, w1}; words = 2; end
            end
            default: ;
        endcase
        if (bad) begin v = 0; f = 0; wb = 0; wv = 0; words = 0; end
    endtask

    task automatic run_op(input string req, input logic [3:0] m, input logic [2:0] r,
                          input logic [1:0] sz, input logic [15:0] w0, input logic [15:0] w1,
                          input int stall, input bit poke);
        logic [31:0] ev, ewv;
        logic ef, ebad, ewb;
        int words;
        logic [15:0] wl [2];
        model(m, r, sz, w0, w1, ev, ef, ebad, ewb, ewv, words);
        wl[0] = w0; wl[1] = w1;
        @(negedge clk);
        mode = m; reg_sel = r; size = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < words; k++) begin
            for (int s = 0; s < stall; s++) begin
                check("R12", "ext_req held", {31'd0, ext_req}, 32'd1);
                check("R12", "no done while req", {31'd0, done}, 32'd0);
                if (poke && k == 0 && s == 0) begin
                    mode = 4'd0; reg_sel = 3'd1; size = 2'd2; start = 1'b1;   // R11 stray start
                end
                @(negedge clk);
                start = 1'b0;
            end
            check("R12", "ext_req for word", {31'd0, ext_req}, 32'd1);
            ext_valid = 1'b1; ext_word = wl[k];
            @(negedge clk);
            ext_valid = 1'b0; ext_word = 16'hdead;
        end
        check(req, "done", {31'd0, done}, 32'd1);
        check(req, "ea_out", ea_out, ev);
        check(req, "needs_fetch", {31'd0, needs_fetch}, {31'd0, ef});
        check(req, "illegal", {31'd0, illegal}, {31'd0, ebad});
        check("R2", "pc_step", {29'd0, pc_step}, 32'(words * 2));
        check(req, "wb_en", {31'd0, wb_en}, {31'd0, ewb});
        if (ewb) begin
            check(req, "wb_reg", {29'd0, wb_reg}, {29'd0, r});
            check(req, "wb_val", wb_val, ewv);
        end
        @(negedge clk);
        check(poke ? "R11" : "R2", "single done", {31'd0, done}, 32'd0);
        check(req, "ext_req idle", {31'd0, ext_req}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            dr[i] = 32'h1357_0000 + 32'(i) * 32'h0101_1111;
            ar[i] = 32'h0002_0000 + 32'(i) * 32'h0000_0340;
        end
        dr[2] = 32'h1234_FFF0;
        ar[5] = 32'h8000_7FFE;
        repeat (3) @(negedge clk);
        check("R2", "reset done", {31'd0, done}, 32'd0);
        check("R12", "reset ext_req", {31'd0, ext_req}, 32'd0);
        check("R3", "reset wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;

        run_op("R1", 4'd0, 3'd3, 2'd2, 16'h0, 16'h0, 0, 0);
        run_op("R1", 4'd1, 3'd6, 2'd1, 16'h0, 16'h0, 0, 0);
        run_op("R1", 4'd12, 3'd0, 2'd2, 16'h0, 16'h0, 0, 0);
        run_op("R6", 4'd2, 3'd4, 2'd1, 16'h0, 16'h0, 0, 0);
        run_op("R3", 4'd3, 3'd2, 2'd1, 16'h0, 16'h0, 0, 0);
        run_op("R3", 4'd3, 3'd5, 2'd2, 16'h0, 16'h0, 0, 0);
        run_op("R4", 4'd4, 3'd1, 2'd2, 16'h0, 16'h0, 0, 0);
        run_op("R4", 4'd4, 3'd6, 2'd1, 16'h0, 16'h0, 0, 0);
        run_op("R5", 4'd3, 3'd3, 2'd0, 16'h0, 16'h0, 0, 0);
        run_op("R5", 4'd3, 3'd7, 2'd0, 16'h0, 16'h0, 0, 0);
        run_op("R5", 4'd4, 3'd7, 2'd0, 16'h0, 16'h0, 0, 0);
        run_op("R5", 4'd4, 3'd0, 2'd0, 16'h0, 16'h0, 0, 0);
        run_op("R6", 4'd5, 3'd2, 2'd1, 16'hFFF8, 16'h0, 0, 0);
        run_op("R6", 4'd9, 3'd0, 2'd1, 16'h0120, 16'h0, 1, 0);
        run_op("R7", 4'd6, 3'd4, 2'd1, 16'h20FC, 16'h0, 0, 0);   // d2, low half sext, disp -4
        run_op("R7", 4'd6, 3'd1, 2'd1, 16'hD810, 16'h0, 2, 0);   // a5, full width, disp +16
        run_op("R7", 4'd10, 3'd0, 2'd2, 16'h3880, 16'h0, 0, 0);  // d3 full, disp -128
        run_op("R8", 4'd7, 3'd0, 2'd1, 16'h8004, 16'h0, 0, 0);
        run_op("R8", 4'd8, 3'd0, 2'd2, 16'hABCD, 16'h1234, 1, 0);
        run_op("R9", 4'd11, 3'd0, 2'd0, 16'h7F9A, 16'h0, 0, 0);
        run_op("R9", 4'd11, 3'd0, 2'd1, 16'hF00D, 16'h0, 0, 0);
        run_op("R9", 4'd11, 3'd0, 2'd2, 16'hCAFE, 16'hBEEF, 2, 0);
        run_op("R10", 4'd13, 3'd2, 2'd1, 16'h0, 16'h0, 0, 0);
        run_op("R10", 4'd15, 3'd2, 2'd1, 16'h0, 16'h0, 0, 0);
        run_op("R10", 4'd3, 3'd2, 2'd3, 16'h0, 16'h0, 0, 0);
        run_op("R11", 4'd8, 3'd0, 2'd2, 16'h0F0F, 16'h5A5A, 3, 1);
        run_op("R11", 4'd5, 3'd6, 2'd1, 16'h7FFF, 16'h0, 2, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule